// File: doc/BRIEF.md
# Bit-Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock using a linear feedback shift register. The generator polynomial is set by two parameters: its degree n and a tap mask that lists every term below x^n. The remainder is the plain polynomial long-division remainder of the message multiplied by x^n. There is no preset value, no output inversion and no bit reflection.

In generate mode the block takes message bits most significant first. After the bit marked as last, it sends the n remainder bits out serially, most significant first, so that they can follow the data on the line. In check mode it takes a whole codeword, which is the data followed by its remainder. After the last bit it reports whether the division left zero. A synchronous clear returns the block to its empty state between messages.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset, and in the cycle after `clear` is high, `remainder` is all zeros, `rem_zero` is 1, `ser_valid` is 0, `done` is 0 and `crc_ok` is 0.
- R2: In generate mode (`mode` = 0), the cycle after the last accepted bit, `remainder` equals (message · x^n) mod G. Bits enter most significant first, one per cycle while `bit_valid` is 1. G has a leading x^n term, and its lower terms are given by `CRC_POLY`, where bit i stands for x^i. The default is n = 16 with mask 16'h8005, which is x^16 + x^15 + x^2 + 1.
- R3: In generate mode, starting in the cycle after the bit with `bit_last` = 1, `ser_valid` is 1 for exactly n cycles. During those cycles `ser_out` carries the remainder, most significant bit first. Afterwards `remainder` is zero.
- R4: `done` is a single-cycle pulse. In generate mode it comes in the cycle right after the last remainder bit. In check mode it comes in the cycle after the bit marked last.
- R5: In check mode (`mode` = 1), a codeword made of the data followed by its n-bit remainder gives `crc_ok` = 1 together with `done`. `crc_ok` holds until the next accepted bit or `clear`.
- R6: In check mode, a codeword with any single bit flipped gives `crc_ok` = 0.
- R7: A cycle with `bit_valid` = 0 leaves `remainder` unchanged. A message sent with idle gaps gives the same remainder as the same message sent without gaps.
- R8: While `ser_valid` is 1, all bit inputs are ignored. The serial remainder stream is unchanged by them.
- R9: With n = 5 and mask 5'b00101 (x^5 + x^2 + 1), the data 10100101 gives remainder 01110. The codeword 1010010101110 then checks as `crc_ok` = 1.
- R10: `clear` in the middle of a message discards the partial remainder. The next message gives the same result as it would straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart, takes priority over every other input |
| mode | input | 1 | 0 = generate, 1 = check |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | `bit_in` is taken this cycle |
| bit_last | input | 1 | Marks the final bit of a message or codeword |
| ser_out | output | 1 | Remainder bit being sent out (0 when idle) |
| ser_valid | output | 1 | `ser_out` carries a remainder bit |
| done | output | 1 | One-cycle end-of-operation pulse |
| remainder | output | CRC_W | Current shift-register contents |
| rem_zero | output | 1 | `remainder` is all zeros |
| crc_ok | output | 1 | Check-mode result: the codeword left zero |

## Verification
Generate mode is tried with several messages. The stated 8-bit pattern tells apart a correctly placed tap from a shifted one. A 16-bit and a 24-bit message drive the feedback over more than one register length. An all-ones message keeps the feedback term set in every cycle. A lone one bit shows the mask itself coming back. An all-zero message must give a zero remainder. Check mode receives the same messages as good codewords and then with one bit flipped, which separates a real zero test from a flag that is always set. Gapped input, noise on the inputs during the serial output, and a clear in mid-message each separate holding, ignoring and restarting from advancing the register by mistake.

// File: rtl/crc_pkg.sv
package crc_pkg;
   typedef enum logic {
      CRC_MODE_GEN   = 1'b0,
      CRC_MODE_CHECK = 1'b1
   } crc_mode_e;
endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
   parameter int              W    = 16,
   parameter logic [W-1:0]    POLY = 16'h8005
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift_en,
   input  logic         unload,
   input  logic         din,
   output logic [W-1:0] rem,
   output logic         nxt_zero
);
   logic         fb;
   logic [W-1:0] step;

   assign fb = rem[W-1] ^ din;

   // one division step; each tap is a parameter-selected variant
   for (genvar i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_low
         if (POLY[0]) begin : g_on
            assign step[0] = fb;
         end else begin : g_off
            assign step[0] = 1'b0;
         end
      end else begin : g_hi
         if (POLY[i]) begin : g_on
            assign step[i] = rem[i-1] ^ fb;
         end else begin : g_off
            assign step[i] = rem[i-1];
         end
      end
   end

   assign nxt_zero = (step == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rem <= '0;
      else if (clr)      rem <= '0;
      else if (unload)   rem <= {rem[W-2:0], 1'b0};
      else if (shift_en) rem <= step;
   end

   // R7: idle cycles keep the register
   assert_hold_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !unload && !shift_en) |=> $stable(rem));

   // R1: clear empties the register
   assert_clear_empty_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (rem == '0));
endmodule

// File: rtl/crc_seq.sv
module crc_seq
   import crc_pkg::*;
#(
   parameter int W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic accept,
   input  logic last,
   input  logic mode,
   input  logic nxt_zero,
   output logic unloading,
   output logic done,
   output logic crc_ok
);
   localparam int CW = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] CNT_END = CW'(W - 1);

   logic [CW-1:0] cnt;
   crc_mode_e     mode_e;

   assign mode_e = crc_mode_e'(mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unloading <= 1'b0;
         cnt       <= '0;
         done      <= 1'b0;
         crc_ok    <= 1'b0;
      end else if (clr) begin
         unloading <= 1'b0;
         cnt       <= '0;
         done      <= 1'b0;
         crc_ok    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (unloading) begin
            if (cnt == CNT_END) begin
               unloading <= 1'b0;
               cnt       <= '0;
               done      <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else if (accept) begin
            crc_ok <= 1'b0;
            if (last) begin
               if (mode_e == CRC_MODE_CHECK) begin
                  crc_ok <= nxt_zero;
                  done   <= 1'b1;
               end else begin
                  unloading <= 1'b1;
                  cnt       <= '0;
               end
            end
         end
      end
   end

   // R4: done never lasts two cycles
   assert_done_pulse_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: the counter stays inside the unload window
   assert_cnt_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      unloading |-> (cnt <= CNT_END));
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine #(
   parameter int                  CRC_W    = 16,
   parameter logic [CRC_W-1:0]    CRC_POLY = 16'h8005
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             mode,
   input  logic             bit_in,
   input  logic             bit_valid,
   input  logic             bit_last,
   output logic             ser_out,
   output logic             ser_valid,
   output logic             done,
   output logic [CRC_W-1:0] remainder,
   output logic             rem_zero,
   output logic             crc_ok
);
   if (CRC_W < 2) begin : g_bad_width
      $error("crc_serial_engine: CRC_W must be at least 2");
   end
   if (!CRC_POLY[0]) begin : g_bad_poly
      $error("crc_serial_engine: generator needs a constant term");
   end

   logic unloading;
   logic accept;
   logic nxt_zero;

   assign accept = bit_valid && !unloading;

   crc_lfsr #(.W(CRC_W), .POLY(CRC_POLY)) u_lfsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clear),
      .shift_en (accept),
      .unload   (unloading),
      .din      (bit_in),
      .rem      (remainder),
      .nxt_zero (nxt_zero)
   );

   crc_seq #(.W(CRC_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clear),
      .accept    (accept),
      .last      (bit_last),
      .mode      (mode),
      .nxt_zero  (nxt_zero),
      .unloading (unloading),
      .done      (done),
      .crc_ok    (crc_ok)
   );

   assign ser_valid = unloading;
   assign ser_out   = unloading ? remainder[CRC_W-1] : 1'b0;
   assign rem_zero  = (remainder == '0);

   // R3: a last bit in generate mode starts the serial output
   assert_unload_start_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && bit_last && !mode && !ser_valid && !clear) |=> ser_valid);

   // R5: a passing check always leaves an empty register
   assert_ok_means_zero_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      crc_ok |-> rem_zero);

   // R1: clear stops any serial output
   assert_clear_idle_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!ser_valid && !crc_ok));
endmodule

// File: tb/tb_crc_serial_engine.sv
`timescale 1ns/1ps
module tb_crc_serial_engine;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   // default 16-bit instance
   logic clear = 0, mode = 0, bit_in = 0, bit_valid = 0, bit_last = 0;
   logic ser_out, ser_valid, done, rem_zero, crc_ok;
   logic [15:0] remainder;

   crc_serial_engine dut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .mode(mode), .bit_in(bit_in),
      .bit_valid(bit_valid), .bit_last(bit_last), .ser_out(ser_out),
      .ser_valid(ser_valid), .done(done), .remainder(remainder),
      .rem_zero(rem_zero), .crc_ok(crc_ok));

   // degree-5 instance
   logic c5 = 0, m5 = 0, b5 = 0, v5 = 0, l5 = 0;
   logic so5, sv5, d5, z5, ok5;
   logic [4:0] r5;

   crc_serial_engine #(.CRC_W(5), .CRC_POLY(5'b00101)) dut5 (
      .clk(clk), .rst_n(rst_n), .clear(c5), .mode(m5), .bit_in(b5),
      .bit_valid(v5), .bit_last(l5), .ser_out(so5), .ser_valid(sv5),
      .done(d5), .remainder(r5), .rem_zero(z5), .crc_ok(ok5));

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // reference: long division of msg*x^16 by the full 17-bit generator
   function automatic logic [15:0] ref_crc(input logic [63:0] msg, input int len);
      logic [79:0] v = {msg, 16'h0};
      logic [79:0] g = {63'h0, 17'h18005};
      for (int i = len + 15; i >= 16; i--)
         if (v[i]) v = v ^ (g << (i - 16));
      return v[15:0];
   endfunction

   // drive len bits MSB first; gap idle cycles after each bit
   task automatic send(input logic [63:0] v, input int len, input bit md,
                       input int gap, input string req);
      logic [15:0] hold;
      mode = md;
      for (int i = len - 1; i >= 0; i--) begin
         @(negedge clk);
         bit_in = v[i]; bit_valid = 1; bit_last = (i == 0);
         if (gap > 0 && i > 0) begin
            @(negedge clk);
            bit_valid = 0; bit_last = 0;
            hold = remainder;
            for (int k = 0; k < gap; k++) begin
               @(negedge clk);
               chk(req, remainder, hold);
            end
         end
      end
      @(negedge clk);
      bit_valid = 0; bit_last = 0;
   endtask

   // expects to be at the negedge right after the last data bit
   task automatic unload_and_check(input logic [15:0] exp, input bit noise);
      logic [15:0] got = '0;
      chk("R2 remainder", remainder, exp);
      for (int k = 0; k < 16; k++) begin
         chk("R3 ser_valid", ser_valid, 1'b1);
         got[15-k] = ser_out;
         if (noise) begin
            bit_valid = 1; bit_in = k[0]; bit_last = 1;
         end
         @(negedge clk);
      end
      bit_valid = 0; bit_last = 0;
      chk(noise ? "R8 stream" : "R3 stream", got, exp);
      chk("R4 done gen", done, 1'b1);
      chk("R3 ser_valid end", ser_valid, 1'b0);
      chk("R3 reg empty", remainder, 16'h0);
      @(negedge clk);
      chk("R4 done single", done, 1'b0);
   endtask

   task automatic t_gen(input logic [63:0] msg, input int len, input int gap, input bit noise);
      logic [15:0] e = ref_crc(msg, len);
      send(msg, len, 1'b0, gap, "R7 hold");
      unload_and_check(e, noise);
   endtask

   task automatic t_check(input logic [63:0] msg, input int len, input int flip);
      logic [63:0] cw = (msg << 16) | 64'(ref_crc(msg, len));
      if (flip >= 0) cw[flip] = ~cw[flip];
      send(cw, len + 16, 1'b1, 0, "R7 hold");
      chk("R4 done chk", done, 1'b1);
      if (flip < 0) chk("R5 crc_ok good", crc_ok, 1'b1);
      else          chk("R6 crc_ok bad", crc_ok, 1'b0);
      @(negedge clk);
      chk("R4 done chk single", done, 1'b0);
      clear = 1; @(negedge clk); clear = 0;
   endtask

   task automatic t_reset();
      chk("R1 rem reset", remainder, 16'h0);
      chk("R1 zero reset", rem_zero, 1'b1);
      chk("R1 sv reset", ser_valid, 1'b0);
      chk("R1 done reset", done, 1'b0);
      chk("R1 ok reset", crc_ok, 1'b0);
   endtask

   task automatic t_clear_mid();
      mode = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); bit_in = 1; bit_valid = 1; bit_last = 0;
      end
      @(negedge clk); bit_valid = 0; clear = 1;
      @(negedge clk); clear = 0;
      chk("R10 cleared", remainder, 16'h0);
      chk("R1 clear zero", rem_zero, 1'b1);
      t_gen(64'hC3, 8, 0, 0);
   endtask

   task automatic t_deg5();
      logic [12:0] cw = 13'b1010010101110;
      logic [4:0]  got = '0;
      m5 = 0;
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk); b5 = cw[i+5]; v5 = 1; l5 = (i == 0);
      end
      @(negedge clk); v5 = 0; l5 = 0;
      chk("R9 rem5", r5, 5'b01110);
      for (int k = 0; k < 5; k++) begin
         got[4-k] = so5;
         @(negedge clk);
      end
      chk("R9 stream5", got, 5'b01110);
      chk("R9 done5", d5, 1'b1);
      m5 = 1;
      for (int i = 12; i >= 0; i--) begin
         @(negedge clk); b5 = cw[i]; v5 = 1; l5 = (i == 0);
      end
      @(negedge clk); v5 = 0; l5 = 0;
      chk("R9 ok5", ok5, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_gen(64'hA5, 8, 0, 0);
      t_gen(64'h1234, 16, 0, 0);
      t_gen(64'hFFFFFF, 24, 0, 0);
      t_gen(64'h1, 1, 0, 0);
      t_gen(64'h00, 8, 0, 0);
      t_gen(64'h5A3C, 16, 2, 0);   // R7 gapped
      t_gen(64'h9E, 8, 0, 1);      // R8 noise during unload
      t_check(64'hA5, 8, -1);
      t_check(64'h1234, 16, -1);
      t_check(64'h1234, 16, 3);
      t_check(64'hFFFFFF, 24, 30);
      t_clear_mid();
      t_deg5();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule